// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Controller

This block sits on the host side of an asynchronous parallel NOR memory that supports page-mode reads. It takes read requests on a valid/ready port, drives the memory's chip-enable, output-enable, write-enable and address pins, samples the data pins when enough time has passed, and returns one data word with a valid strobe. It handles one read at a time.

A page is 16 bytes, which is 8 words. The controller remembers which page is open while chip enable stays low. A read that lands in the open page waits only the short intra-page latency. A read to another page, or the first read after chip enable was released, waits the full random-access latency. After a set number of idle cycles, chip enable is released and the open-page record is dropped. Every latency is a parameter counted in clock cycles. The bus can run in a 16-bit word configuration or an 8-bit byte configuration. In byte configuration the lowest byte-address bit leaves on data pin 15, which the memory then uses as an address input.

Top module: `pflash_rd_ctrl`

## Requirements
- R1: `mem_we_n` is 1 in every cycle.
- R2: Before a read from the released state, `mem_addr` is driven for one cycle with `mem_ce_n` still high. `mem_addr` does not change from that cycle until the data is sampled.
- R3: A request accepted while chip enable is released produces `rsp_valid` exactly 1+max(FULL_LAT,OE_LAT) cycles after the accepting edge.
- R4: A request accepted while a page is open, whose page bits equal the open page, produces `rsp_valid` max(PAGE_LAT,OE_LAT) cycles after acceptance.
- R5: A request accepted while a page is open, whose page bits differ from the open page, produces `rsp_valid` max(FULL_LAT,OE_LAT) cycles after acceptance, and its page becomes the open page.
- R6: Counting from the first cycle after a response, if IDLE_REL consecutive cycles pass with no request, `mem_ce_n` returns to 1 and the page record is cleared. A request presented in cycle IDLE_REL-1 is still a page hit. After a release, the next read takes the R3 latency even if it falls in the same page.
- R7: `mem_oe_n` is 0 only while `mem_ce_n` is 0, and it is 0 exactly during the sampling window of a read.
- R8: With `cfg_word`=0 (byte configuration): `mem_addr` = `req_addr[ADDR_W-1:1]`; `mem_dq15_oe`=1 and `mem_dq15_o` = `req_addr[0]`; `rsp_data` = {8'h00, `mem_dq_i[7:0]`}; `mem_dq_i[15:8]` has no effect.
- R9: With `cfg_word`=1 (word configuration): `mem_addr` = `req_addr[ADDR_W-1:1]`; `req_addr[0]` is ignored; `mem_dq15_oe`=0; `rsp_data` = `mem_dq_i[15:0]`.
- R10: In both configurations the page is `req_addr[ADDR_W-1:4]`. The word within the page is `req_addr[3:1]` in word configuration and the byte within the page is `req_addr[3:0]` in byte configuration. Only the page bits decide hit or miss.
- R11: `req_ready` is 0 from the edge that accepts a request until the edge that raises `rsp_valid`. A request held during that time is accepted at the first edge where `req_ready` is 1.
- R12: During and just after reset: `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `rsp_valid` is 0, `req_ready` is 1, and no page is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus; change only while chip enable is released |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | One-cycle strobe for returned data |
| rsp_data | output | 16 | Returned data; upper byte is zero in byte configuration |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, held high |
| mem_addr | output | ADDR_W-1 | Memory word address pins |
| mem_dq15_o | output | 1 | Value for data pin 15 in byte configuration (lowest address bit) |
| mem_dq15_oe | output | 1 | Drive enable for data pin 15 |
| mem_dq_i | input | 16 | Memory data pins as seen by the controller |

## Verification
Some rules are checked by assertions on every cycle: write enable stays high, output enable is low only under chip enable, the address is stable when chip enable falls and during each sampling window, ready drops after each acceptance, the upper byte is zero in byte configuration, and the open-page record is never set and cleared in the same cycle. Only the bench scenarios can show that each read picks the right latency class (first access, page hit, page miss, and the hit versus release boundary at the idle limit) and that the correct byte or word comes back. They show this because the bench's memory model returns garbage whenever the controller samples too early, and because response timing is compared cycle by cycle against a behavioural model.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

   typedef enum logic [1:0] {
      PF_OFF    = 2'd0,   // chip enable released, no page open
      PF_SETUP  = 2'd1,   // address driven, chip enable still high
      PF_ACCESS = 2'd2,   // chip and output enable low, counting latency
      PF_OPEN   = 2'd3    // chip enable held low, page record valid
   } pf_state_e;

   function automatic int unsigned pf_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pflash_lat_timer.sv
module pflash_lat_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("pflash_lat_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = (cnt_q == CNT_W'(1));

   // a zero load would never expire and hang the access (R3, R4, R5)
   assert_timer_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0));

endmodule

// File: rtl/pflash_page_track.sv
module pflash_page_track #(
   parameter int unsigned PAGE_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic              clr,
   input  logic [PAGE_W-1:0] req_page,
   output logic              hit
);

   logic [PAGE_W-1:0] page_q;
   logic              valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q  <= '0;
         valid_q <= 1'b0;
      end else if (clr) begin
         valid_q <= 1'b0;
      end else if (upd) begin
         page_q  <= req_page;
         valid_q <= 1'b1;
      end
   end

   assign hit = valid_q && (page_q == req_page);

   // a release and a new page record never happen together (R6)
   assert_track_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd && clr));

endmodule

// File: rtl/pflash_bus_map.sv
module pflash_bus_map #(
   parameter int unsigned ADDR_W  = 24,
   parameter bit          BYTE_EN = 1'b1
) (
   input  logic              cfg_word,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [15:0]       dq_i,
   output logic [ADDR_W-2:0] mem_addr,
   output logic              dq15_o,
   output logic              dq15_oe,
   output logic [15:0]       rd_data
);

   logic byte_sel;

   if (BYTE_EN) begin : g_byte_cap
      assign byte_sel = ~cfg_word;
   end else begin : g_word_only
      logic unused_cfg;
      assign unused_cfg = cfg_word;
      assign byte_sel   = 1'b0;
   end

   assign mem_addr = addr_q[ADDR_W-1:1];
   assign dq15_o   = addr_q[0];
   assign dq15_oe  = byte_sel;
   assign rd_data  = byte_sel ? {8'h00, dq_i[7:0]} : dq_i;

endmodule

// File: rtl/pflash_rd_ctrl.sv
module pflash_rd_ctrl
   import pflash_pkg::*;
#(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned FULL_LAT = 10,
   parameter int unsigned PAGE_LAT = 3,
   parameter int unsigned OE_LAT   = 4,
   parameter int unsigned IDLE_REL = 6,
   parameter bit          BYTE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_word,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [15:0]       rsp_data,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-2:0] mem_addr,
   output logic              mem_dq15_o,
   output logic              mem_dq15_oe,
   input  logic [15:0]       mem_dq_i
);

   localparam int unsigned FULL_EFF = pf_max(FULL_LAT, OE_LAT);
   localparam int unsigned PAGE_EFF = pf_max(PAGE_LAT, OE_LAT);
   localparam int unsigned CNT_W    = $clog2(FULL_EFF + 1);
   localparam int unsigned IDLE_W   = $clog2(IDLE_REL + 1);
   localparam int unsigned PAGE_W   = ADDR_W - 4;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("pflash_rd_ctrl: ADDR_W must be at least 6");
   end
   if (FULL_LAT < 1 || OE_LAT < 1) begin : g_bad_full
      $error("pflash_rd_ctrl: FULL_LAT and OE_LAT must be at least 1");
   end
   if (PAGE_LAT < 1 || PAGE_LAT > FULL_LAT) begin : g_bad_page
      $error("pflash_rd_ctrl: PAGE_LAT must lie in 1..FULL_LAT");
   end
   if (IDLE_REL < 1) begin : g_bad_idle
      $error("pflash_rd_ctrl: IDLE_REL must be at least 1");
   end

   pf_state_e         state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [IDLE_W-1:0] idle_q;
   logic              acc, page_hit, release_now;
   logic              t_load, t_expire;
   logic [CNT_W-1:0]  t_val;
   logic [15:0]       rd_data;
   logic              rsp_valid_q;
   logic [15:0]       rsp_data_q;

   assign req_ready = (state_q == PF_OFF) || (state_q == PF_OPEN);
   assign acc       = req_valid && req_ready;

   always_comb begin
      state_d     = state_q;
      t_load      = 1'b0;
      t_val       = CNT_W'(FULL_EFF);
      release_now = 1'b0;
      case (state_q)
         PF_OFF:    if (acc) state_d = PF_SETUP;
         PF_SETUP: begin
            state_d = PF_ACCESS;
            t_load  = 1'b1;
         end
         PF_ACCESS: if (t_expire) state_d = PF_OPEN;
         PF_OPEN: begin
            if (acc) begin
               state_d = PF_ACCESS;
               t_load  = 1'b1;
               t_val   = page_hit ? CNT_W'(PAGE_EFF) : CNT_W'(FULL_EFF);
            end else if (idle_q == IDLE_W'(IDLE_REL - 1)) begin
               state_d     = PF_OFF;
               release_now = 1'b1;
            end
         end
         default:   state_d = PF_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PF_OFF;
         addr_q      <= '0;
         idle_q      <= '0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         state_q     <= state_d;
         rsp_valid_q <= 1'b0;
         if (acc) addr_q <= req_addr;
         if (state_q != PF_OPEN || acc) begin
            idle_q <= '0;
         end else begin
            idle_q <= idle_q + 1'b1;
         end
         if (state_q == PF_ACCESS && t_expire) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= rd_data;
         end
      end
   end

   pflash_lat_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expire   (t_expire)
   );

   pflash_page_track #(.PAGE_W(PAGE_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (acc),
      .clr      (release_now),
      .req_page (req_addr[ADDR_W-1:4]),
      .hit      (page_hit)
   );

   pflash_bus_map #(.ADDR_W(ADDR_W), .BYTE_EN(BYTE_EN)) u_map (
      .cfg_word (cfg_word),
      .addr_q   (addr_q),
      .dq_i     (mem_dq_i),
      .mem_addr (mem_addr),
      .dq15_o   (mem_dq15_o),
      .dq15_oe  (mem_dq15_oe),
      .rd_data  (rd_data)
   );

   assign mem_ce_n  = (state_q == PF_OFF) || (state_q == PF_SETUP);
   assign mem_oe_n  = (state_q != PF_ACCESS);
   assign mem_we_n  = 1'b1;
   assign rsp_valid = rsp_valid_q;
   assign rsp_data  = rsp_data_q;

   assert_we_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_n);

   assert_addr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> $stable(mem_addr));

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

   assert_oe_under_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_ce_n);

   assert_one_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_byte_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !cfg_word && BYTE_EN) |-> (rsp_data[15:8] == 8'h00));

endmodule

// File: tb/pflash_rd_ctrl_bench.sv
module pflash_rd_ctrl_bench;

   localparam int AW = 24;
   localparam int FL = 10;
   localparam int PL = 3;
   localparam int OL = 4;
   localparam int IR = 6;
   localparam int FE = (FL > OL) ? FL : OL;
   localparam int PE = (PL > OL) ? PL : OL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_word = 1'b1;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0]   mem_dq_i = 16'hDEAD;
   logic          req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n;
   logic          mem_dq15_o, mem_dq15_oe;
   logic [15:0]   rsp_data;
   logic [AW-2:0] mem_addr;

   always #5 clk = ~clk;

   pflash_rd_ctrl #(.ADDR_W(AW), .FULL_LAT(FL), .PAGE_LAT(PL), .OE_LAT(OL),
                    .IDLE_REL(IR), .BYTE_EN(1'b1)) u_pflash_rd_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq15_o(mem_dq15_o),
      .mem_dq15_oe(mem_dq15_oe), .mem_dq_i(mem_dq_i));

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   // behavioural reference state
   bit            m_busy = 0, m_open = 0, m_acc = 0;
   int            m_rem = 0, m_idle = 0;
   logic [AW-5:0] m_page = '0;
   logic [AW-1:0] m_addr = '0;
   logic [15:0]   m_exp = '0;
   string         m_tag = "R3";

   // memory timing model
   int            pg_age = 0, wd_age = 0, oe_age = 0;
   bit            last_ce_low = 0;
   logic [AW-2:0] last_ma = '0;
   logic          last_b = 1'b0;

   function automatic logic [15:0] mem_word(input logic [AW-2:0] w);
      return w[15:0] ^ 16'h3C96 ^ {w[22:16], 9'h0};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic mem_model();
      logic b;
      b = cfg_word ? 1'b0 : mem_dq15_o;
      if (mem_ce_n) begin
         pg_age = 0; wd_age = 0;
      end else if (!last_ce_low || mem_addr[AW-2:3] != last_ma[AW-2:3]) begin
         pg_age = 1; wd_age = 1;
      end else begin
         pg_age++;
         if (mem_addr[2:0] != last_ma[2:0] || b != last_b) wd_age = 1;
         else wd_age++;
      end
      oe_age = mem_oe_n ? 0 : oe_age + 1;
      last_ce_low = !mem_ce_n; last_ma = mem_addr; last_b = b;
      if (pg_age >= FL && wd_age >= PL && oe_age >= OL) begin
         if (cfg_word) mem_dq_i = mem_word(mem_addr);
         else begin
            logic [15:0] w;
            w = mem_word(mem_addr);
            mem_dq_i = {1'b1, 7'h6B, (mem_dq15_o ? w[15:8] : w[7:0])};
         end
      end else begin
         mem_dq_i = 16'hDEAD;
      end
   endtask

   task automatic tick();
      bit            lreq;
      logic [AW-1:0] laddr;
      lreq  = req_valid;
      laddr = req_addr;
      @(negedge clk);
      cyc++;
      m_acc = 0;
      if (cyc > 150000) begin
         chk(0, "watchdog", cyc, 150000);
      end
      chk(mem_we_n == 1'b1, "R1", mem_we_n, 1);
      if (m_busy) begin
         m_rem--;
         if (m_rem == 0) begin
            chk(rsp_valid == 1'b1, m_tag, rsp_valid, 1);
            chk(rsp_data == m_exp, cfg_word ? "R9" : "R8", rsp_data, m_exp);
            chk(mem_addr == m_addr[AW-1:1], "R10", mem_addr, m_addr[AW-1:1]);
            if (cfg_word) chk(mem_dq15_oe == 1'b0, "R9", mem_dq15_oe, 0);
            else chk(mem_dq15_oe && mem_dq15_o == m_addr[0], "R8",
                     {mem_dq15_oe, mem_dq15_o}, {1'b1, m_addr[0]});
            chk(req_ready == 1'b1, "R11", req_ready, 1);
            m_busy = 0; m_open = 1; m_idle = 0;
         end else begin
            chk(rsp_valid == 1'b0, m_tag, rsp_valid, 0);
            chk(req_ready == 1'b0, "R11", req_ready, 0);
         end
      end else if (lreq) begin
         m_acc = 1; m_addr = laddr;
         if (!m_open) begin
            m_rem = 1 + FE; m_tag = "R3";
         end else if (laddr[AW-1:4] == m_page) begin
            m_rem = PE; m_tag = "R4";
         end else begin
            m_rem = FE; m_tag = "R5";
         end
         m_page = laddr[AW-1:4];
         if (cfg_word) m_exp = mem_word(laddr[AW-1:1]);
         else begin
            logic [15:0] w;
            w = mem_word(laddr[AW-1:1]);
            m_exp = {8'h00, (laddr[0] ? w[15:8] : w[7:0])};
         end
         m_busy = 1;
         chk(rsp_valid == 1'b0, m_tag, rsp_valid, 0);
         chk(req_ready == 1'b0, "R11", req_ready, 0);
      end else begin
         if (m_open) begin
            if (m_idle == IR - 1) m_open = 0;
            else m_idle++;
         end
         chk(rsp_valid == 1'b0, "R6", rsp_valid, 0);
         chk(req_ready == 1'b1, "R11", req_ready, 1);
      end
      mem_model();
   endtask

   task automatic issue(input logic [AW-1:0] a);
      req_valid = 1'b1;
      req_addr  = a;
      for (int i = 0; i < 1000 && !m_acc; i++) tick();
      if (!m_acc) chk(0, "watchdog", 0, 1);
      req_valid = 1'b0;
   endtask

   task automatic finish_rd();
      for (int i = 0; i < 1000 && m_busy; i++) tick();
      if (m_busy) chk(0, "watchdog", 0, 1);
   endtask

   task automatic rd(input logic [AW-1:0] a, input int gap);
      for (int i = 0; i < gap; i++) tick();
      issue(a);
      finish_rd();
   endtask

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n, "R12", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
      chk(!rsp_valid && req_ready, "R12", {rsp_valid, req_ready}, 2'b01);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_ce_n == 1'b1 && req_ready == 1'b1, "R12", {mem_ce_n, req_ready}, 2'b11);

      // word configuration
      rd(24'h000100, 0);         // R3 first access
      rd(24'h000106, 0);         // R4 hit
      rd(24'h00010E, 2);         // R4 hit after a gap
      rd(24'h000200, 0);         // R5 miss while open
      rd(24'h000202, IR - 1);    // R6 last idle cycle still a hit
      rd(24'h000204, IR);        // R6 released: full latency, same page
      rd(24'h000211, 0);         // R10 page bits from addr[23:4], R9 bit0 ignored
      rd(24'h00021F, 0);         // R4 hit in that page
      // R11: request held while busy
      issue(24'hABCDE0);
      req_valid = 1'b1; req_addr = 24'hABCDE8;
      for (int i = 0; i < 1000 && !(m_acc && m_addr == 24'hABCDE8); i++) tick();
      req_valid = 1'b0;
      finish_rd();

      // release, then switch to byte configuration
      repeat (IR + 3) tick();
      chk(mem_ce_n == 1'b1 && mem_oe_n == 1'b1, "R6", {mem_ce_n, mem_oe_n}, 2'b11);
      cfg_word = 1'b0;
      rd(24'h000301, 0);         // R8 odd byte, R3
      rd(24'h000300, 0);         // R8 even byte same word, R4
      rd(24'h00030F, 1);         // R10 byte index addr[3:0], R4
      rd(24'h000310, 0);         // R5 miss
      rd(24'h00031B, IR);        // R6 release in byte configuration
      repeat (IR + 3) tick();
      cfg_word = 1'b1;
      rd(24'h123457, 3);         // R9 back in word configuration
      repeat (4) tick();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule